// File: doc/BRIEF.md
# Banked Internal Data Memory Controller

This block owns the 8-bit internal data address space of a small processor core. The lower half of the space (00h-7Fh) is general RAM that the block stores itself. The upper half (80h-FFh) belongs to special function registers, which live outside this block. A direct access to the upper half is passed unchanged to an external register decoder over a pass-through bus, and that decoder's read data is returned.

Three access ports share the storage. The direct port addresses all 256 locations. The indirect port reaches only the RAM half: a read above 7Fh gives FFh and a write there is dropped. The register port takes a 3-bit working-register number and places it in one of four 8-byte banks at the bottom of RAM. The bank is chosen by two bank-select bits, which are bits 4 and 3 of the program status word. Writes take effect on the clock edge. Reads are combinational from the stored array. There is no external data memory.

The design is a datapath rather than a sequencer, so it has no states and no transitions. It consists of an address resolver, a single-write, multi-read storage array and one read-source selector per port.

Top module: `idm_ctrl`

## Requirements
- R1: After reset every RAM location reads 00h through any port.
- R2: A direct write with an address below 80h stores its data on the next rising clock edge. A direct read below 80h returns the stored byte in the same cycle.
- R3: Indirect and direct accesses below 80h reach the same storage, so a byte written through one port reads back through the other.
- R4: A direct access at or above 80h behaves as follows. `sfr_rd`/`sfr_wr` follow the direct strobes, `sfr_addr` equals the direct address, `sfr_wdata` equals the direct write data, and `dir_rdata` returns `sfr_rdata`. RAM is not changed.
- R5: An indirect read at or above 80h returns FFh. An indirect write at or above 80h changes no RAM location and raises no SFR strobe.
- R6: A register-port access reaches RAM address `{bank, reg_num}`, which is bank×8 plus the register number. `psw_rs[1]` carries PSW bit 4 (bank MSB) and `psw_rs[0]` carries PSW bit 3.
- R7: A register-port write reaches only the selected bank. The same register number in the other banks keeps its value.
- R8: A port whose read strobe is low drives 00h on its read data.
- R9: When several RAM writes fall in the same cycle, only one is performed, with priority direct over indirect over register. A direct access at or above 80h is not a RAM write and does not block the others.
- R10: A direct access below 80h never raises `sfr_rd` or `sfr_wr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, clears RAM |
| dir_addr | input | 8 | Direct-port address |
| dir_rd | input | 1 | Direct-port read strobe |
| dir_wr | input | 1 | Direct-port write strobe |
| dir_wdata | input | 8 | Direct-port write data |
| dir_rdata | output | 8 | Direct-port read data |
| ind_addr | input | 8 | Indirect-port address |
| ind_rd | input | 1 | Indirect-port read strobe |
| ind_wr | input | 1 | Indirect-port write strobe |
| ind_wdata | input | 8 | Indirect-port write data |
| ind_rdata | output | 8 | Indirect-port read data |
| reg_num | input | 3 | Working-register number |
| reg_rd | input | 1 | Register-port read strobe |
| reg_wr | input | 1 | Register-port write strobe |
| reg_wdata | input | 8 | Register-port write data |
| reg_rdata | output | 8 | Register-port read data |
| psw_rs | input | 2 | Bank select: [1] = PSW bit 4, [0] = PSW bit 3 |
| sfr_addr | output | 8 | Address to the external register decoder |
| sfr_rd | output | 1 | Register-decoder read strobe |
| sfr_wr | output | 1 | Register-decoder write strobe |
| sfr_wdata | output | 8 | Write data to the register decoder |
| sfr_rdata | input | 8 | Read data from the register decoder |

## Verification
The only internal state is the RAM array. A bad byte there shows up on the next read of that address through any of the three ports. Such a read can come as soon as the cycle after the write.

A wrong bank translation or a wrong write priority corrupts a byte other than the one that was aimed at. To catch this, the bench reads back the neighbouring locations: other banks, and the lower 7 bits of an upper-half address.

Routing errors are combinational and appear in the same cycle at the read-data and SFR-bus ports. This covers a wrong source for read data and a leaked or missing SFR strobe.

// File: rtl/idm_pkg.sv
package idm_pkg;

    localparam int IDM_DW     = 8;   // data width
    localparam int IDM_AW     = 8;   // internal address width
    localparam int IDM_BANK_W = 2;   // bank-select width
    localparam int IDM_REG_W  = 3;   // working-register number width
    localparam int IDM_NPORT  = 3;   // direct, indirect, register

    typedef enum logic [1:0] {
        PT_DIR = 2'd0,
        PT_IND = 2'd1,
        PT_REG = 2'd2
    } port_e;

    typedef enum logic [1:0] {
        SRC_ZERO = 2'd0,
        SRC_RAM  = 2'd1,
        SRC_SFR  = 2'd2,
        SRC_ONES = 2'd3
    } src_e;

endpackage

// File: rtl/idm_addr_map.sv
module idm_addr_map
    import idm_pkg::*;
#(
    parameter int DW     = IDM_DW,
    parameter int AW     = IDM_AW,
    parameter int BANK_W = IDM_BANK_W,
    parameter int REG_W  = IDM_REG_W,
    parameter int NPORT  = IDM_NPORT,
    localparam int RAW   = AW - 1,
    localparam int PAD   = RAW - BANK_W - REG_W
) (
    input  logic [AW-1:0]              dir_addr,
    input  logic                       dir_rd,
    input  logic                       dir_wr,
    input  logic [DW-1:0]              dir_wdata,
    input  logic [AW-1:0]              ind_addr,
    input  logic                       ind_rd,
    input  logic                       ind_wr,
    input  logic [DW-1:0]              ind_wdata,
    input  logic [REG_W-1:0]           reg_num,
    input  logic                       reg_rd,
    input  logic                       reg_wr,
    input  logic [DW-1:0]              reg_wdata,
    input  logic [BANK_W-1:0]          bank,
    output logic [NPORT-1:0][RAW-1:0]  rd_addr,
    output src_e [NPORT-1:0]           rd_src,
    output logic                       wr_en,
    output logic [RAW-1:0]             wr_addr,
    output logic [DW-1:0]              wr_data,
    output logic [AW-1:0]              sfr_addr,
    output logic                       sfr_rd,
    output logic                       sfr_wr,
    output logic [DW-1:0]              sfr_wdata
);

    logic           dir_hi;
    logic           ind_hi;
    logic [RAW-1:0] reg_phys;
    logic           dir_ram_wr;
    logic           ind_ram_wr;

    assign dir_hi   = dir_addr[AW-1];
    assign ind_hi   = ind_addr[AW-1];
    assign reg_phys = {{PAD{1'b0}}, bank, reg_num};

    // read address per port
    always_comb begin
        rd_addr[PT_DIR] = dir_addr[RAW-1:0];
        rd_addr[PT_IND] = ind_addr[RAW-1:0];
        rd_addr[PT_REG] = reg_phys;
    end

    // read source per port
    always_comb begin
        if (!dir_rd)       rd_src[PT_DIR] = SRC_ZERO;
        else if (dir_hi)   rd_src[PT_DIR] = SRC_SFR;
        else               rd_src[PT_DIR] = SRC_RAM;

        if (!ind_rd)       rd_src[PT_IND] = SRC_ZERO;
        else if (ind_hi)   rd_src[PT_IND] = SRC_ONES;
        else               rd_src[PT_IND] = SRC_RAM;

        if (!reg_rd)       rd_src[PT_REG] = SRC_ZERO;
        else               rd_src[PT_REG] = SRC_RAM;
    end

    // single RAM write, fixed priority
    assign dir_ram_wr = dir_wr && !dir_hi;
    assign ind_ram_wr = ind_wr && !ind_hi;

    always_comb begin
        wr_en   = 1'b0;
        wr_addr = '0;
        wr_data = '0;
        if (dir_ram_wr) begin
            wr_en   = 1'b1;
            wr_addr = dir_addr[RAW-1:0];
            wr_data = dir_wdata;
        end else if (ind_ram_wr) begin
            wr_en   = 1'b1;
            wr_addr = ind_addr[RAW-1:0];
            wr_data = ind_wdata;
        end else if (reg_wr) begin
            wr_en   = 1'b1;
            wr_addr = reg_phys;
            wr_data = reg_wdata;
        end
    end

    // pass-through to the register decoder
    assign sfr_addr  = dir_addr;
    assign sfr_rd    = dir_rd && dir_hi;
    assign sfr_wr    = dir_wr && dir_hi;
    assign sfr_wdata = dir_wdata;

endmodule

// File: rtl/idm_ram.sv
module idm_ram #(
    parameter int DW    = 8,
    parameter int AW    = 7,
    parameter int NRD   = 3,
    localparam int WORDS = 1 << AW
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we,
    input  logic [AW-1:0]           waddr,
    input  logic [DW-1:0]           wdata,
    input  logic [NRD-1:0][AW-1:0]  raddr,
    output logic [NRD-1:0][DW-1:0]  rdata
);

    logic [DW-1:0] mem [WORDS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rdata[p] = mem[raddr[p]];
    end

endmodule

// File: rtl/idm_rd_sel.sv
module idm_rd_sel
    import idm_pkg::*;
#(
    parameter int DW = IDM_DW
) (
    input  src_e          src,
    input  logic [DW-1:0] ram_q,
    input  logic [DW-1:0] sfr_q,
    output logic [DW-1:0] q
);

    always_comb begin
        unique case (src)
            SRC_RAM:  q = ram_q;
            SRC_SFR:  q = sfr_q;
            SRC_ONES: q = '1;
            SRC_ZERO: q = '0;
            default:  q = '0;
        endcase
    end

endmodule

// File: rtl/idm_ctrl.sv
module idm_ctrl
    import idm_pkg::*;
#(
    parameter int DW     = IDM_DW,
    parameter int AW     = IDM_AW,
    parameter int BANK_W = IDM_BANK_W,
    parameter int REG_W  = IDM_REG_W,
    localparam int NPORT = IDM_NPORT,
    localparam int RAW   = AW - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     dir_addr,
    input  logic              dir_rd,
    input  logic              dir_wr,
    input  logic [DW-1:0]     dir_wdata,
    output logic [DW-1:0]     dir_rdata,
    input  logic [AW-1:0]     ind_addr,
    input  logic              ind_rd,
    input  logic              ind_wr,
    input  logic [DW-1:0]     ind_wdata,
    output logic [DW-1:0]     ind_rdata,
    input  logic [REG_W-1:0]  reg_num,
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    input  logic [BANK_W-1:0] psw_rs,
    output logic [AW-1:0]     sfr_addr,
    output logic              sfr_rd,
    output logic              sfr_wr,
    output logic [DW-1:0]     sfr_wdata,
    input  logic [DW-1:0]     sfr_rdata
);

    logic [NPORT-1:0][RAW-1:0] rd_addr;
    src_e [NPORT-1:0]          rd_src;
    logic [NPORT-1:0][DW-1:0]  ram_q;
    logic [NPORT-1:0][DW-1:0]  port_q;
    logic                      wr_en;
    logic [RAW-1:0]            wr_addr;
    logic [DW-1:0]             wr_data;

    idm_addr_map #(
        .DW(DW), .AW(AW), .BANK_W(BANK_W), .REG_W(REG_W), .NPORT(NPORT)
    ) u_map (
        .dir_addr (dir_addr),
        .dir_rd   (dir_rd),
        .dir_wr   (dir_wr),
        .dir_wdata(dir_wdata),
        .ind_addr (ind_addr),
        .ind_rd   (ind_rd),
        .ind_wr   (ind_wr),
        .ind_wdata(ind_wdata),
        .reg_num  (reg_num),
        .reg_rd   (reg_rd),
        .reg_wr   (reg_wr),
        .reg_wdata(reg_wdata),
        .bank     (psw_rs),
        .rd_addr  (rd_addr),
        .rd_src   (rd_src),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .sfr_addr (sfr_addr),
        .sfr_rd   (sfr_rd),
        .sfr_wr   (sfr_wr),
        .sfr_wdata(sfr_wdata)
    );

    idm_ram #(.DW(DW), .AW(RAW), .NRD(NPORT)) u_ram (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (wr_en),
        .waddr(wr_addr),
        .wdata(wr_data),
        .raddr(rd_addr),
        .rdata(ram_q)
    );

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        idm_rd_sel #(.DW(DW)) u_sel (
            .src  (rd_src[p]),
            .ram_q(ram_q[p]),
            .sfr_q(sfr_rdata),
            .q    (port_q[p])
        );
    end

    assign dir_rdata = port_q[PT_DIR];
    assign ind_rdata = port_q[PT_IND];
    assign reg_rdata = port_q[PT_REG];

endmodule

// File: rtl/idm_ctrl_chk.sv
module idm_ctrl_chk #(
    parameter int DW     = 8,
    parameter int AW     = 8,
    parameter int BANK_W = 2,
    parameter int REG_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [AW-1:0]     dir_addr,
    input logic              dir_rd,
    input logic              dir_wr,
    input logic [DW-1:0]     dir_wdata,
    input logic [DW-1:0]     dir_rdata,
    input logic [AW-1:0]     ind_addr,
    input logic              ind_rd,
    input logic              ind_wr,
    input logic [DW-1:0]     ind_wdata,
    input logic [DW-1:0]     ind_rdata,
    input logic [REG_W-1:0]  reg_num,
    input logic              reg_rd,
    input logic              reg_wr,
    input logic [DW-1:0]     reg_wdata,
    input logic [DW-1:0]     reg_rdata,
    input logic [BANK_W-1:0] psw_rs,
    input logic [AW-1:0]     sfr_addr,
    input logic              sfr_rd,
    input logic              sfr_wr,
    input logic [DW-1:0]     sfr_wdata,
    input logic [DW-1:0]     sfr_rdata
);

    // R2: a low direct write is visible to a direct read of the same address next cycle
    a_r2_dir_writeback: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_wr && !dir_addr[AW-1])
        |=> (!(dir_rd && dir_addr == $past(dir_addr)) || dir_rdata == $past(dir_wdata)));

    // R3: a low direct write is visible to an indirect read of the same address next cycle
    a_r3_ind_sees_dir: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_wr && !dir_addr[AW-1])
        |=> (!(ind_rd && ind_addr == $past(dir_addr)) || ind_rdata == $past(dir_wdata)));

    // R4: upper-half direct read returns decoder data
    a_r4_sfr_return: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_rd && dir_addr[AW-1]) |-> (dir_rdata == sfr_rdata && sfr_addr == dir_addr));

    // R5: upper-half indirect read gives all ones
    a_r5_ind_high_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (ind_rd && ind_addr[AW-1]) |-> ind_rdata == '1);

    // R5: indirect traffic alone never reaches the decoder
    a_r5_ind_no_sfr: assert property (@(posedge clk) disable iff (!rst_n)
        (ind_wr && !dir_wr && !dir_rd) |-> (!sfr_wr && !sfr_rd));

    // R8: idle read ports drive zero
    a_r8_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!dir_rd && !ind_rd && !reg_rd)
        |-> (dir_rdata == '0 && ind_rdata == '0 && reg_rdata == '0));

    // R10: low direct addresses never strobe the decoder
    a_r10_low_no_sfr: assert property (@(posedge clk) disable iff (!rst_n)
        !dir_addr[AW-1] |-> (!sfr_rd && !sfr_wr));

endmodule

bind idm_ctrl idm_ctrl_chk #(.DW(DW), .AW(AW), .BANK_W(BANK_W), .REG_W(REG_W)) u_chk (.*);

// File: tb/sim_idm_ctrl.sv
`timescale 1ns/1ps
module sim_idm_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] dir_addr = '0, dir_wdata = '0, ind_addr = '0, ind_wdata = '0;
    logic [7:0] reg_wdata = '0;
    logic       dir_rd = 0, dir_wr = 0, ind_rd = 0, ind_wr = 0, reg_rd = 0, reg_wr = 0;
    logic [2:0] reg_num = '0;
    logic [1:0] psw_rs = '0;
    logic [7:0] dir_rdata, ind_rdata, reg_rdata, sfr_addr, sfr_wdata, sfr_rdata;
    logic       sfr_rd, sfr_wr;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 0;

    always #5 clk = ~clk;

    // external register decoder model
    assign sfr_rdata = sfr_addr ^ 8'h5A;

    idm_ctrl u0 (
        .clk(clk), .rst_n(rst_n),
        .dir_addr(dir_addr), .dir_rd(dir_rd), .dir_wr(dir_wr),
        .dir_wdata(dir_wdata), .dir_rdata(dir_rdata),
        .ind_addr(ind_addr), .ind_rd(ind_rd), .ind_wr(ind_wr),
        .ind_wdata(ind_wdata), .ind_rdata(ind_rdata),
        .reg_num(reg_num), .reg_rd(reg_rd), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .psw_rs(psw_rs),
        .sfr_addr(sfr_addr), .sfr_rd(sfr_rd), .sfr_wr(sfr_wr),
        .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata)
    );

    // scoreboard: 0 dir_rdata, 1 ind_rdata, 2 reg_rdata, 3 sfr_addr,
    // 4 {sfr_wr,sfr_rd}, 5 sfr_wdata
    typedef struct {
        int         sel;
        logic [7:0] exp;
        string      tag;
    } item_t;

    item_t sbq[$];
    event  pushed;

    function automatic logic [7:0] observe(int sel);
        case (sel)
            0: return dir_rdata;
            1: return ind_rdata;
            2: return reg_rdata;
            3: return sfr_addr;
            4: return {6'b0, sfr_wr, sfr_rd};
            default: return sfr_wdata;
        endcase
    endfunction

    initial begin : monitor
        forever begin
            @(pushed);
            while (sbq.size() != 0) begin
                item_t it;
                logic [7:0] act;
                it  = sbq.pop_front();
                act = observe(it.sel);
                n_vec++;
                if (act !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s sel=%0d actual=%02h expected=%02h", it.tag, it.sel, act, it.exp);
                end
            end
        end
    end

    task automatic expect_val(int sel, logic [7:0] exp, string tag);
        item_t it;
        it.sel = sel; it.exp = exp; it.tag = tag;
        sbq.push_back(it);
        -> pushed;
    endtask

    task automatic idle();
        dir_rd = 0; dir_wr = 0; ind_rd = 0; ind_wr = 0; reg_rd = 0; reg_wr = 0;
    endtask

    task automatic settle();
        #1;
    endtask

    task automatic wr_dir(logic [7:0] a, logic [7:0] d);
        @(negedge clk); idle(); dir_addr = a; dir_wdata = d; dir_wr = 1;
        @(negedge clk); idle();
    endtask

    task automatic wr_ind(logic [7:0] a, logic [7:0] d);
        @(negedge clk); idle(); ind_addr = a; ind_wdata = d; ind_wr = 1;
        @(negedge clk); idle();
    endtask

    task automatic wr_reg(logic [1:0] b, logic [2:0] n, logic [7:0] d);
        @(negedge clk); idle(); psw_rs = b; reg_num = n; reg_wdata = d; reg_wr = 1;
        @(negedge clk); idle();
    endtask

    task automatic rd_dir(logic [7:0] a, logic [7:0] exp, string tag);
        @(negedge clk); idle(); dir_addr = a; dir_rd = 1;
        settle(); expect_val(0, exp, tag); settle();
    endtask

    task automatic rd_ind(logic [7:0] a, logic [7:0] exp, string tag);
        @(negedge clk); idle(); ind_addr = a; ind_rd = 1;
        settle(); expect_val(1, exp, tag); settle();
    endtask

    task automatic rd_reg(logic [1:0] b, logic [2:0] n, logic [7:0] exp, string tag);
        @(negedge clk); idle(); psw_rs = b; reg_num = n; reg_rd = 1;
        settle(); expect_val(2, exp, tag); settle();
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin : driver
        repeat (2) @(negedge clk);
        rst_n = 1'b1;

        // R1: cleared after reset, every port
        rd_dir(8'h00, 8'h00, "R1");
        rd_dir(8'h7F, 8'h00, "R1");
        rd_ind(8'h40, 8'h00, "R1");
        rd_reg(2'b11, 3'd7, 8'h00, "R1");

        // R2: direct write then read
        wr_dir(8'h10, 8'hA5);
        rd_dir(8'h10, 8'hA5, "R2");
        wr_dir(8'h7F, 8'h3C);
        rd_dir(8'h7F, 8'h3C, "R2");

        // R8: strobe low gives zero even on a loaded address
        @(negedge clk); idle(); dir_addr = 8'h10; ind_addr = 8'h10;
        settle(); expect_val(0, 8'h00, "R8"); expect_val(1, 8'h00, "R8"); settle();

        // R3: shared storage between direct and indirect
        rd_ind(8'h10, 8'hA5, "R3");
        wr_ind(8'h22, 8'h77);
        rd_dir(8'h22, 8'h77, "R3");

        // R5: indirect above 7Fh
        rd_ind(8'h90, 8'hFF, "R5");
        @(negedge clk); idle(); ind_addr = 8'h85; ind_wdata = 8'hEE; ind_wr = 1;
        settle(); expect_val(4, 8'h00, "R5"); settle();
        @(negedge clk); idle();
        rd_dir(8'h05, 8'h00, "R5");

        // R4: direct upper-half read and write go to the decoder
        @(negedge clk); idle(); dir_addr = 8'hA2; dir_rd = 1;
        settle();
        expect_val(4, 8'h01, "R4");
        expect_val(3, 8'hA2, "R4");
        expect_val(0, 8'hA2 ^ 8'h5A, "R4");
        settle();
        @(negedge clk); idle(); dir_addr = 8'h90; dir_wdata = 8'hC3; dir_wr = 1;
        settle();
        expect_val(4, 8'h02, "R4");
        expect_val(5, 8'hC3, "R4");
        settle();
        @(negedge clk); idle();
        rd_dir(8'h10, 8'hA5, "R4");

        // R10: low direct access does not strobe the decoder
        @(negedge clk); idle(); dir_addr = 8'h10; dir_rd = 1; dir_wr = 1; dir_wdata = 8'hA5;
        settle(); expect_val(4, 8'h00, "R10"); settle();
        @(negedge clk); idle();

        // R6: bank translation {bank, reg}
        wr_reg(2'b10, 3'd5, 8'h5B);
        rd_dir(8'h15, 8'h5B, "R6");
        wr_reg(2'b01, 3'd0, 8'h61);
        rd_dir(8'h08, 8'h61, "R6");
        rd_reg(2'b01, 3'd0, 8'h61, "R6");

        // R7: only the selected bank changes
        wr_reg(2'b00, 3'd2, 8'h11);
        wr_reg(2'b11, 3'd2, 8'h33);
        rd_reg(2'b00, 3'd2, 8'h11, "R7");
        rd_reg(2'b11, 3'd2, 8'h33, "R7");
        rd_reg(2'b01, 3'd2, 8'h00, "R7");
        rd_dir(8'h1A, 8'h33, "R7");
        rd_dir(8'h02, 8'h11, "R7");

        // R9: simultaneous writes, direct wins
        @(negedge clk); idle(); psw_rs = 2'b00;
        dir_addr = 8'h30; dir_wdata = 8'hD1; dir_wr = 1;
        ind_addr = 8'h30; ind_wdata = 8'hD2; ind_wr = 1;
        reg_num = 3'd0; reg_wdata = 8'hD3; reg_wr = 1;
        @(negedge clk); idle();
        rd_dir(8'h30, 8'hD1, "R9");
        rd_dir(8'h00, 8'h00, "R9");
        // indirect beats register
        @(negedge clk); idle(); psw_rs = 2'b00;
        ind_addr = 8'h31; ind_wdata = 8'hE2; ind_wr = 1;
        reg_num = 3'd1; reg_wdata = 8'hE3; reg_wr = 1;
        @(negedge clk); idle();
        rd_dir(8'h31, 8'hE2, "R9");
        rd_dir(8'h01, 8'h00, "R9");
        // upper-half direct write does not block the indirect one
        @(negedge clk); idle();
        dir_addr = 8'hB2; dir_wdata = 8'h99; dir_wr = 1;
        ind_addr = 8'h32; ind_wdata = 8'hF2; ind_wr = 1;
        @(negedge clk); idle();
        rd_ind(8'h32, 8'hF2, "R9");

        @(negedge clk); idle();
        #1;
        if (sbq.size() != 0) begin
            n_bad++;
            $display("FAIL scoreboard actual=%0d expected=0 pending items", sbq.size());
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule